// File: doc/BRIEF.md
# Nonvolatile Array Program/Erase Controller

This block manages a 4 KB nonvolatile data array behind a byte-wide synchronous CPU bus. It decodes a four-byte control window and the array window. It gates ordinary array reads with an enable bit. It runs program and erase jobs through a guarded sequence of three steps. First the CPU arms the controller by setting the latch bit, together with the erase flag and the size code. Next it writes the target location, which captures the address and the data. Only then is the high-voltage enable accepted. A cycle counter times the job, and the array changes only when the count runs out.

Erasing returns cells to 0xFF. Programming can only clear bits. A location must therefore be erased before it can be given an arbitrary new value. Program and erase jobs can be started and finished while ordinary array access is disabled. When array access is disabled, a lower-priority device can answer at the array addresses.

The sequencer has four states, which move as follows:
- IDLE goes to LATCHED when the latch bit is set without the enable bit.
- LATCHED goes to ARMED when an array write captures the target.
- ARMED goes to HV when the enable bit is written.
- HV goes back to LATCHED when the count expires (the commit) or when the enable bit is cleared (an abort).
- LATCHED and ARMED both go to IDLE when the latch bit is cleared.

Top module: `nvm_ctrl`

## Requirements
- R1: Bus addresses 0x00F0–0x00F3 are always claimed (`bus_claim`=1 during a strobe). Addresses 0x1000–0x1FFF are claimed only while bit 0 of register 0x00F0 (the array enable) is 1. Unclaimed reads return 0x00.
- R2: A claimed array read returns the stored byte in the same cycle. The array starts fully erased (0xFF).
- R3: A write to an array address while the latch bit is 0 leaves the array unchanged.
- R4: Register 0x00F1 holds bit0 latch, bit1 erase (1=erase, 0=program), bits[3:2] size (00 byte, 01 word, 10 row, 11 bulk), bit4 high-voltage enable and bit7 busy (read-only). An array write while latched captures the address and data.
- R5: Writing bit4=1 before any target has been captured is ignored: 0x00F1 keeps its value and no job starts.
- R6: Once started, busy (and bit4) read 1 for exactly OP_CYCLES clock cycles. The array is then updated, and bit0 of 0x00F2 (done) is set. Any write to 0x00F2 clears done.
- R7: A program job ANDs the captured data into the target, so bits are only ever cleared. A word program applies the data to both bytes of the aligned pair and ignores address bit 0.
- R8: An erase job sets 0xFF on one byte, on the aligned word (address bit 0 ignored), on the 32-byte row selected by offset bits [11:5], or on the whole array.
- R9: While busy, array writes and register 0x00F1 writes that keep bit4=1 are ignored, including any change to the latch, erase or size fields.
- R10: Writing bit4=0 while busy aborts the job. The array is left unchanged, done is not set, and the latch stays set.
- R11: Reset clears 0x00F1 and 0x00F2, sets the array enable to 1, and abandons any pending job without touching the array.
- R12: Program and erase jobs run and complete correctly while the array enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | 8 | Read data (combinational) |
| bus_claim | output | 1 | Block responds to the current access |

## Verification
Most corruption of the sequencer state becomes visible on the very next read of 0x00F1. A stuck latch, a lost capture or a wrong busy flag each change the latch bit or bit7 there. An error in the count or in the commit step shows as a wrong array byte, or as a wrong done bit, one cycle after the count expires. Cases are also read exactly at the last busy cycle and at the first cycle after it. An error in the size decode only shows on a neighbouring byte at the edge of the word or the row, so those neighbours are read back after each erase.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_LATCHED = 2'd1,
        S_ARMED   = 2'd2,
        S_HV      = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_ROW  = 2'd2,
        SZ_BULK = 2'd3
    } op_size_e;

    localparam int CTL_LATCH = 0;
    localparam int CTL_ERASE = 1;
    localparam int CTL_SZ_LO = 2;
    localparam int CTL_HV    = 4;
    localparam int CTL_BUSY  = 7;

    localparam logic [1:0] RIDX_INIT = 2'd0;
    localparam logic [1:0] RIDX_CTL  = 2'd1;
    localparam logic [1:0] RIDX_STAT = 2'd2;
endpackage

// File: rtl/nvm_decode.sv
module nvm_decode #(
    parameter int ADDR_W    = 16,
    parameter int AW        = 12,
    parameter int REG_BASE  = 'h00F0,
    parameter int ARR_BASE  = 'h1000,
    parameter int ARR_BYTES = 4096
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic              arr_en,
    output logic              reg_hit,
    output logic [1:0]        reg_idx,
    output logic              arr_hit,
    output logic [AW-1:0]     arr_off,
    output logic              claim
);
    localparam logic [ADDR_W-1:0] REG_B = ADDR_W'(REG_BASE);
    localparam logic [ADDR_W-1:0] ARR_B = ADDR_W'(ARR_BASE);
    localparam logic [ADDR_W:0]   ARR_E = (ADDR_W+1)'(ARR_BASE + ARR_BYTES);

    logic [ADDR_W-1:0] diff;

    always_comb begin
        diff    = addr - ARR_B;
        reg_hit = (addr[ADDR_W-1:2] == REG_B[ADDR_W-1:2]);
        reg_idx = addr[1:0];
        arr_hit = (addr >= ARR_B) && ({1'b0, addr} < ARR_E);
        arr_off = diff[AW-1:0];
        claim   = (rd || wr) && (reg_hit || (arr_hit && arr_en));
    end
endmodule

// File: rtl/nvm_seq.sv
module nvm_seq
    import nvm_pkg::*;
#(
    parameter int AW        = 12,
    parameter int OP_CYCLES = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_we,
    input  logic [7:0]    ctl_wdata,
    input  logic          arr_we,
    input  logic [AW-1:0] arr_off,
    input  logic [7:0]    arr_wdata,
    input  logic          done_clr,
    output seq_state_e    st_q,
    output logic          erase_q,
    output op_size_e      size_q,
    output logic [AW-1:0] tgt_off,
    output logic [7:0]    tgt_data,
    output logic          busy,
    output logic          commit,
    output logic          done_q
);
    localparam int CW = (OP_CYCLES > 1) ? $clog2(OP_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_TOP = CW'(OP_CYCLES - 1);

    seq_state_e    st_d;
    logic [CW-1:0] cnt_q;
    logic          w_latch, w_hv, fld_we, cap_we, start;

    always_comb begin
        w_latch = ctl_wdata[CTL_LATCH];
        w_hv    = ctl_wdata[CTL_HV];
        st_d    = st_q;
        unique case (st_q)
            S_IDLE: begin
                if (ctl_we && w_latch && !w_hv) st_d = S_LATCHED;
            end
            S_LATCHED: begin
                if (ctl_we && !w_latch && !w_hv) st_d = S_IDLE;
                else if (arr_we)                 st_d = S_ARMED;
            end
            S_ARMED: begin
                if (ctl_we && w_hv)              st_d = S_HV;
                else if (ctl_we && !w_latch)     st_d = S_IDLE;
            end
            S_HV: begin
                if (ctl_we && !w_hv)             st_d = S_LATCHED;
                else if (cnt_q == '0)            st_d = S_LATCHED;
            end
            default: st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        busy   = (st_q == S_HV);
        commit = busy && (cnt_q == '0) && !(ctl_we && !w_hv);
        fld_we = ctl_we && w_latch && !w_hv && (st_q != S_HV);
        cap_we = arr_we && ((st_q == S_LATCHED) || (st_q == S_ARMED));
        start  = (st_q == S_ARMED) && ctl_we && w_hv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            erase_q  <= 1'b0;
            size_q   <= SZ_BYTE;
            tgt_off  <= '0;
            tgt_data <= 8'hFF;
            cnt_q    <= '0;
            done_q   <= 1'b0;
        end else begin
            if (fld_we) begin
                erase_q <= ctl_wdata[CTL_ERASE];
                size_q  <= op_size_e'(ctl_wdata[CTL_SZ_LO +: 2]);
            end
            if (cap_we) begin
                tgt_off  <= arr_off;
                tgt_data <= arr_wdata;
            end
            if (start)                cnt_q <= CNT_TOP;
            else if (busy && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
            if (commit)        done_q <= 1'b1;
            else if (done_clr) done_q <= 1'b0;
        end
    end

    p_hv_needs_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(st_q) == S_ARMED));
    p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(size_q) && $stable(erase_q) && $stable(tgt_off)));
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_TOP);
    p_done_after_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (done_q && !busy));
endmodule

// File: rtl/nvm_store.sv
module nvm_store
    import nvm_pkg::*;
#(
    parameter int AW        = 12,
    parameter int DEPTH     = 4096,
    parameter int ROW_BYTES = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_off,
    output logic [7:0]    rd_data,
    input  logic          commit,
    input  logic          erase,
    input  op_size_e      size,
    input  logic [AW-1:0] tgt_off,
    input  logic [7:0]    tgt_data
);
    localparam int RB = $clog2(ROW_BYTES);

    logic [7:0] mem [DEPTH];

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
    end

    function automatic logic in_scope(input logic [AW-1:0] idx,
                                      input logic [AW-1:0] tgt,
                                      input op_size_e      sz);
        unique case (sz)
            SZ_BYTE: return idx == tgt;
            SZ_WORD: return idx[AW-1:1] == tgt[AW-1:1];
            SZ_ROW:  return idx[AW-1:RB] == tgt[AW-1:RB];
            default: return 1'b1;
        endcase
    endfunction

    always_ff @(posedge clk) begin
        if (commit) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (in_scope(AW'(i), tgt_off, erase ? size :
                             ((size == SZ_WORD) ? SZ_WORD : SZ_BYTE))) begin
                    mem[i] <= erase ? 8'hFF : (mem[i] & tgt_data);
                end
            end
        end
    end

    assign rd_data = mem[rd_off];

    p_bulk_erased_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && erase && size == SZ_BULK) |=>
            (mem[0] == 8'hFF && mem[DEPTH-1] == 8'hFF));
endmodule

// File: rtl/nvm_ctrl.sv
module nvm_ctrl
    import nvm_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int REG_BASE  = 'h00F0,
    parameter int ARR_BASE  = 'h1000,
    parameter int ARR_BYTES = 4096,
    parameter int ROW_BYTES = 32,
    parameter int OP_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output logic [7:0]        bus_rdata,
    output logic              bus_claim
);
    localparam int AW = $clog2(ARR_BYTES);

    logic          reg_hit, arr_hit, en_q;
    logic [1:0]    reg_idx;
    logic [AW-1:0] arr_off, tgt_off;
    logic [7:0]    tgt_data, arr_rdata;
    logic          erase_q, busy, commit, done_q;
    seq_state_e    st_q;
    op_size_e      size_q;
    logic          ctl_we, arr_we, done_clr, init_we;

    nvm_decode #(
        .ADDR_W(ADDR_W), .AW(AW), .REG_BASE(REG_BASE),
        .ARR_BASE(ARR_BASE), .ARR_BYTES(ARR_BYTES)
    ) u_dec (
        .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .arr_en(en_q),
        .reg_hit(reg_hit), .reg_idx(reg_idx), .arr_hit(arr_hit),
        .arr_off(arr_off), .claim(bus_claim)
    );

    always_comb begin
        init_we  = bus_wr && reg_hit && (reg_idx == RIDX_INIT);
        ctl_we   = bus_wr && reg_hit && (reg_idx == RIDX_CTL);
        done_clr = bus_wr && reg_hit && (reg_idx == RIDX_STAT);
        arr_we   = bus_wr && arr_hit && !busy;
    end

    nvm_seq #(.AW(AW), .OP_CYCLES(OP_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(bus_wdata),
        .arr_we(arr_we), .arr_off(arr_off), .arr_wdata(bus_wdata),
        .done_clr(done_clr), .st_q(st_q), .erase_q(erase_q), .size_q(size_q),
        .tgt_off(tgt_off), .tgt_data(tgt_data), .busy(busy),
        .commit(commit), .done_q(done_q)
    );

    nvm_store #(.AW(AW), .DEPTH(ARR_BYTES), .ROW_BYTES(ROW_BYTES)) u_mem (
        .clk(clk), .rst_n(rst_n), .rd_off(arr_off), .rd_data(arr_rdata),
        .commit(commit), .erase(erase_q), .size(size_q),
        .tgt_off(tgt_off), .tgt_data(tgt_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       en_q <= 1'b1;
        else if (init_we) en_q <= bus_wdata[0];
    end

    always_comb begin
        bus_rdata = 8'h00;
        if (bus_rd && bus_claim) begin
            if (reg_hit) begin
                unique case (reg_idx)
                    RIDX_INIT: bus_rdata = {7'b0, en_q};
                    RIDX_CTL:  bus_rdata = {busy, 2'b00, busy, size_q,
                                            erase_q, (st_q != S_IDLE)};
                    RIDX_STAT: bus_rdata = {7'b0, done_q};
                    default:   bus_rdata = 8'h00;
                endcase
            end else begin
                bus_rdata = arr_rdata;
            end
        end
    end

    p_array_gated_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && arr_hit && !en_q) |-> (!bus_claim && bus_rdata == 8'h00));
    p_regs_visible_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd || bus_wr) && reg_hit) |-> bus_claim);
endmodule

// File: tb/nvm_ctrl_test.sv
module nvm_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int OPC        = 8;
    localparam int WD_CYCLES  = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_rdata;
    logic        bus_claim;

    int errors = 0;
    int checks = 0;

    logic [7:0] q_data[$];
    logic       q_claim[$];
    string      q_tag[$];

    nvm_ctrl #(.OP_CYCLES(OPC)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
        .bus_claim(bus_claim)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // monitor: compares each scored read against the queued expectation
    always @(negedge clk) begin
        if (bus_rd && q_data.size() > 0) begin
            automatic logic [7:0] ed = q_data.pop_front();
            automatic logic       ec = q_claim.pop_front();
            automatic string      et = q_tag.pop_front();
            checks++;
            if (bus_rdata !== ed || bus_claim !== ec) begin
                errors++;
                $display("FAIL %s addr=%h: got data=%h claim=%b, expected data=%h claim=%b",
                         et, bus_addr, bus_rdata, bus_claim, ed, ec);
            end
        end
    end

    task automatic wr_b(input logic [15:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [15:0] a, input logic [7:0] d,
                          input logic c, input string tag);
        q_data.push_back(d); q_claim.push_back(c); q_tag.push_back(tag);
        @(posedge clk); #1;
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic run_op(input logic [7:0] ctl, input logic [15:0] a,
                          input logic [7:0] d);
        wr_b(16'h00F1, ctl);
        wr_b(a, d);
        wr_b(16'h00F1, ctl | 8'h10);
        repeat (OPC + 4) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // reset state
        rd_chk(16'h00F0, 8'h01, 1'b1, "R11 init reset");
        rd_chk(16'h00F1, 8'h00, 1'b1, "R11 ctl reset");
        rd_chk(16'h00F2, 8'h00, 1'b1, "R11 status reset");
        rd_chk(16'h00F3, 8'h00, 1'b1, "R1 spare reg claimed");
        rd_chk(16'h1000, 8'hFF, 1'b1, "R2 erased array");
        rd_chk(16'h2000, 8'h00, 1'b0, "R1 outside window");

        // plain write ignored
        wr_b(16'h1000, 8'h00);
        rd_chk(16'h1000, 8'hFF, 1'b1, "R3 plain write");

        // enable before capture
        wr_b(16'h00F1, 8'h01);
        rd_chk(16'h00F1, 8'h01, 1'b1, "R4 latch set");
        wr_b(16'h00F1, 8'h11);
        rd_chk(16'h00F1, 8'h01, 1'b1, "R5 hv without capture");

        // byte program, busy window at its last cycle
        wr_b(16'h1005, 8'h5A);
        wr_b(16'h00F1, 8'h11);
        repeat (OPC - 2) @(posedge clk);
        rd_chk(16'h00F1, 8'h91, 1'b1, "R6 busy last cycle");
        repeat (4) @(posedge clk);
        rd_chk(16'h1005, 8'h5A, 1'b1, "R4 captured program");
        rd_chk(16'h00F2, 8'h01, 1'b1, "R6 done set");
        rd_chk(16'h00F1, 8'h01, 1'b1, "R6 idle after job");
        wr_b(16'h00F2, 8'h00);
        rd_chk(16'h00F2, 8'h00, 1'b1, "R6 done cleared");

        // program only clears bits
        run_op(8'h01, 16'h1005, 8'h0F);
        rd_chk(16'h1005, 8'h0A, 1'b1, "R7 and-only program");

        // first cycle after busy
        wr_b(16'h00F1, 8'h01);
        wr_b(16'h1006, 8'h33);
        wr_b(16'h00F1, 8'h11);
        repeat (OPC - 1) @(posedge clk);
        rd_chk(16'h00F1, 8'h01, 1'b1, "R6 busy ends");
        rd_chk(16'h1006, 8'h33, 1'b1, "R6 array updated");

        // word program ignores bit 0
        run_op(8'h05, 16'h1011, 8'hC3);
        rd_chk(16'h1010, 8'hC3, 1'b1, "R7 word low");
        rd_chk(16'h1011, 8'hC3, 1'b1, "R7 word high");
        rd_chk(16'h1012, 8'hFF, 1'b1, "R7 word neighbour");

        // byte erase
        run_op(8'h03, 16'h1005, 8'h00);
        rd_chk(16'h1005, 8'hFF, 1'b1, "R8 byte erase");
        rd_chk(16'h1006, 8'h33, 1'b1, "R8 byte erase neighbour");

        // word erase at odd address
        run_op(8'h07, 16'h1011, 8'h00);
        rd_chk(16'h1010, 8'hFF, 1'b1, "R8 word erase low");
        rd_chk(16'h1011, 8'hFF, 1'b1, "R8 word erase high");

        // row erase
        run_op(8'h01, 16'h1020, 8'h11);
        run_op(8'h01, 16'h103F, 8'h22);
        run_op(8'h01, 16'h1040, 8'h44);
        run_op(8'h0B, 16'h1033, 8'h00);
        rd_chk(16'h1020, 8'hFF, 1'b1, "R8 row first");
        rd_chk(16'h103F, 8'hFF, 1'b1, "R8 row last");
        rd_chk(16'h1040, 8'h44, 1'b1, "R8 next row kept");
        rd_chk(16'h1006, 8'h33, 1'b1, "R8 previous row kept");

        // writes during busy
        wr_b(16'h00F1, 8'h01);
        wr_b(16'h1100, 8'h11);
        wr_b(16'h00F1, 8'h11);
        wr_b(16'h1101, 8'h00);
        wr_b(16'h00F1, 8'h1F);
        rd_chk(16'h00F1, 8'h91, 1'b1, "R9 ctl frozen");
        repeat (OPC + 2) @(posedge clk);
        rd_chk(16'h1100, 8'h11, 1'b1, "R9 target programmed");
        rd_chk(16'h1101, 8'hFF, 1'b1, "R9 busy write ignored");

        // abort
        wr_b(16'h00F2, 8'h00);
        wr_b(16'h00F1, 8'h01);
        wr_b(16'h1200, 8'h00);
        wr_b(16'h00F1, 8'h11);
        wr_b(16'h00F1, 8'h01);
        repeat (OPC + 2) @(posedge clk);
        rd_chk(16'h1200, 8'hFF, 1'b1, "R10 abort keeps array");
        rd_chk(16'h00F1, 8'h01, 1'b1, "R10 latch kept");
        rd_chk(16'h00F2, 8'h00, 1'b1, "R10 no done");

        // array disabled
        wr_b(16'h00F0, 8'h00);
        rd_chk(16'h1000, 8'h00, 1'b0, "R1 array unclaimed");
        rd_chk(16'h00F1, 8'h01, 1'b1, "R1 regs still claimed");
        run_op(8'h01, 16'h1300, 8'h77);
        wr_b(16'h00F0, 8'h01);
        rd_chk(16'h1300, 8'h77, 1'b1, "R12 program while disabled");

        // reset mid-job
        wr_b(16'h00F0, 8'h00);
        wr_b(16'h00F1, 8'h01);
        wr_b(16'h1400, 8'h00);
        wr_b(16'h00F1, 8'h11);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        rd_chk(16'h00F1, 8'h00, 1'b1, "R11 ctl cleared");
        rd_chk(16'h00F0, 8'h01, 1'b1, "R11 enable restored");
        repeat (OPC + 2) @(posedge clk);
        rd_chk(16'h1400, 8'hFF, 1'b1, "R11 job abandoned");
        rd_chk(16'h1300, 8'h77, 1'b1, "R11 array retained");

        // bulk erase
        run_op(8'h0F, 16'h1000, 8'h00);
        rd_chk(16'h1006, 8'hFF, 1'b1, "R8 bulk low");
        rd_chk(16'h1040, 8'hFF, 1'b1, "R8 bulk mid");
        rd_chk(16'h1300, 8'hFF, 1'b1, "R8 bulk data");
        rd_chk(16'h1FFF, 8'hFF, 1'b1, "R8 bulk top");

        repeat (3) @(posedge clk);
        if (q_data.size() != 0) begin
            errors++; checks++;
            $display("FAIL scoreboard: got %0d pending, expected 0", q_data.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule